// File: doc/BRIEF.md
# Inverter-Programmed Multiplexer Logic Cell

This block is a purely combinational logic element with no lookup memory. Eight data lines each pass through an inverter that one static configuration bit controls. The results feed two four-way multiplexers, a lower half on lines 0..3 and an upper half on lines 4..7. A top selector then picks one half, which makes a single eight-way multiplexer.

A two-bit mode word sets how the cell is used:

- **Mode 0:** a full eight-way mux steered by an external top-select line.
- **Mode 1:** two independent four-way muxes, with the top select held at 1.
- **Modes 2 and 3:** lookup-table use. Every data line is replaced by logic 1 ahead of its inverter, so the inversion bits hold the inverted truth table. The address bits above the configured table width are forced to 0.

Top module: `mcell_core`

## Requirements
- R1: In mode 0 (full mux), with k = {tbs_i, sel_a_i} where tbs_i is the MSB, y_o equals din_i[k] XOR cfg_inv_i[k]. With all inputs at 0, y_o is 0.
- R2: In mode 0, y_lo_o equals din_i[sel_a_i]^cfg_inv_i[sel_a_i] and y_hi_o equals din_i[4+sel_a_i]^cfg_inv_i[4+sel_a_i]. sel_b_i has no effect in this mode.
- R3: In mode 1 (dual), y_lo_o equals din_i[sel_a_i]^cfg_inv_i[sel_a_i] and y_hi_o equals din_i[4+sel_b_i]^cfg_inv_i[4+sel_b_i]. The top select is held at 1, so y_o equals y_hi_o whatever tbs_i is.
- R4: In mode 2 (full table) with cfg_lut_size_i = 3, y_o equals NOT cfg_inv_i[lut_addr_i], with lut_addr_i bit 0 as the LSB. Loading truth-table bit T[k] as cfg_inv_i[k] = ~T[k] therefore gives y_o = T[lut_addr_i].
- R5: In mode 2, the effective address is lut_addr_i with every bit at position cfg_lut_size_i or above forced to 0. Size 1 keeps only bit 0, size 2 keeps bits 1..0, and size 0 always addresses entry 0.
- R6: In mode 3 (half table), the table uses entries 0..3 only. A size of 3 acts as 2, the top select is 0, and y_o = y_lo_o = NOT cfg_inv_i[effective address].
- R7: In modes 2 and 3, din_i, sel_a_i, sel_b_i and tbs_i have no effect on any output. y_hi_o equals NOT cfg_inv_i[4 + effective address bits 1..0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_mode_i | input | 2 | Static mode: 0 full mux, 1 dual, 2 full table, 3 half table |
| cfg_inv_i | input | 8 | Static per-line inversion bits |
| cfg_lut_size_i | input | 2 | Table width in address bits (0..3) |
| din_i | input | 8 | Data lines in mux modes |
| sel_a_i | input | 2 | Lower-half select; low select bits in mode 0 |
| sel_b_i | input | 2 | Upper-half select in dual mode |
| tbs_i | input | 1 | Top select (MSB) in mode 0 |
| lut_addr_i | input | 3 | Table address in modes 2 and 3 |
| y_o | output | 1 | Cell output after the top select |
| y_lo_o | output | 1 | Lower four-way mux output |
| y_hi_o | output | 1 | Upper four-way mux output |

## Verification
In dual mode both halves resolve in the same cycle from unrelated selects, and tbs_i is driven at the same time to a random value it must not affect. The bench sweeps all sixteen select pairs under random inversion and data. It judges y_lo_o, y_hi_o and y_o together against a behavioural model on every clock. In the table modes the same overlap is provoked: random data, selects and top-select values are driven alongside each table address, and all three outputs must still follow only the inversion bits and the masked address.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

    localparam int MC_HALF_N = 4;
    localparam int MC_IN_N   = 2 * MC_HALF_N;
    localparam int MC_HSEL_W = $clog2(MC_HALF_N);
    localparam int MC_SEL_W  = MC_HSEL_W + 1;
    localparam int MC_SIZE_W = $clog2(MC_SEL_W + 1);

    typedef enum logic [1:0] {
        MC_MUX8     = 2'd0,
        MC_DUAL     = 2'd1,
        MC_LUT_FULL = 2'd2,
        MC_LUT_HALF = 2'd3
    } mc_mode_e;

    typedef struct packed {
        logic [MC_HSEL_W-1:0] sel_lo;
        logic [MC_HSEL_W-1:0] sel_hi;
        logic                 top_sel;
        logic                 tie_const;
    } mc_route_t;

    // keep address bits below min(size, cap)
    function automatic logic [MC_SEL_W-1:0] mc_addr_mask(
        input logic [MC_SIZE_W-1:0] size,
        input int                   cap
    );
        logic [MC_SEL_W-1:0] m;
        int lim;
        lim = (int'(size) > cap) ? cap : int'(size);
        for (int i = 0; i < MC_SEL_W; i++) begin
            m[i] = (i < lim);
        end
        return m;
    endfunction

endpackage

// File: rtl/mcell_invert.sv
module mcell_invert #(
    parameter int N = 8
) (
    input  logic [N-1:0] din_i,
    input  logic [N-1:0] inv_i,
    input  logic         tie_i,
    output logic [N-1:0] v_o
);
    for (genvar k = 0; k < N; k++) begin : g_line
        logic src;
        assign src    = tie_i ? 1'b1 : din_i[k];
        assign v_o[k] = src ^ inv_i[k];
    end
endmodule

// File: rtl/mcell_mux4.sv
module mcell_mux4 #(
    parameter int N  = 4,
    localparam int SW = $clog2(N)
) (
    input  logic [N-1:0]  d_i,
    input  logic [SW-1:0] sel_i,
    output logic          y_o
);
    assign y_o = d_i[sel_i];
endmodule

// File: rtl/mcell_route.sv
module mcell_route
    import mcell_pkg::*;
(
    input  mc_mode_e                mode_i,
    input  logic [MC_HSEL_W-1:0]    sel_a_i,
    input  logic [MC_HSEL_W-1:0]    sel_b_i,
    input  logic                    tbs_i,
    input  logic [MC_SIZE_W-1:0]    size_i,
    input  logic [MC_SEL_W-1:0]     addr_i,
    output mc_route_t               route_o
);
    logic [MC_SEL_W-1:0] eff_full, eff_half;

    assign eff_full = addr_i & mc_addr_mask(size_i, MC_SEL_W);
    assign eff_half = addr_i & mc_addr_mask(size_i, MC_HSEL_W);

    always_comb begin
        route_o = '0;
        unique case (mode_i)
            MC_MUX8: begin
                route_o.sel_lo  = sel_a_i;
                route_o.sel_hi  = sel_a_i;
                route_o.top_sel = tbs_i;
            end
            MC_DUAL: begin
                route_o.sel_lo  = sel_a_i;
                route_o.sel_hi  = sel_b_i;
                route_o.top_sel = 1'b1;
            end
            MC_LUT_FULL: begin
                route_o.sel_lo    = eff_full[MC_HSEL_W-1:0];
                route_o.sel_hi    = eff_full[MC_HSEL_W-1:0];
                route_o.top_sel   = eff_full[MC_SEL_W-1];
                route_o.tie_const = 1'b1;
            end
            default: begin
                route_o.sel_lo    = eff_half[MC_HSEL_W-1:0];
                route_o.sel_hi    = eff_half[MC_HSEL_W-1:0];
                route_o.top_sel   = 1'b0;
                route_o.tie_const = 1'b1;
            end
        endcase
    end

    // R5: a one-bit table never reaches past entry 1
    always_comb begin
        if ((mode_i == MC_LUT_FULL || mode_i == MC_LUT_HALF) && size_i == 1) begin
            p_narrow_table_r5: assert (route_o.top_sel == 1'b0 && route_o.sel_lo <= 1)
                else $error("p_narrow_table_r5");
        end
    end
endmodule

// File: rtl/mcell_core.sv
module mcell_core
    import mcell_pkg::*;
(
    input  logic [1:0] cfg_mode_i,
    input  logic [7:0] cfg_inv_i,
    input  logic [1:0] cfg_lut_size_i,
    input  logic [7:0] din_i,
    input  logic [1:0] sel_a_i,
    input  logic [1:0] sel_b_i,
    input  logic       tbs_i,
    input  logic [2:0] lut_addr_i,
    output logic       y_o,
    output logic       y_lo_o,
    output logic       y_hi_o
);
    mc_mode_e                         mode;
    mc_route_t                        route;
    logic [MC_IN_N-1:0]               lines;
    logic [1:0][MC_HSEL_W-1:0]        hsel;
    logic [1:0]                       half_y;

    assign mode = mc_mode_e'(cfg_mode_i);

    mcell_route u_route (
        .mode_i  (mode),
        .sel_a_i (sel_a_i),
        .sel_b_i (sel_b_i),
        .tbs_i   (tbs_i),
        .size_i  (cfg_lut_size_i),
        .addr_i  (lut_addr_i),
        .route_o (route)
    );

    mcell_invert #(.N(MC_IN_N)) u_inv (
        .din_i (din_i),
        .inv_i (cfg_inv_i),
        .tie_i (route.tie_const),
        .v_o   (lines)
    );

    assign hsel[0] = route.sel_lo;
    assign hsel[1] = route.sel_hi;

    for (genvar h = 0; h < 2; h++) begin : g_half
        mcell_mux4 #(.N(MC_HALF_N)) u_mux (
            .d_i   (lines[h*MC_HALF_N +: MC_HALF_N]),
            .sel_i (hsel[h]),
            .y_o   (half_y[h])
        );
    end

    assign y_lo_o = half_y[0];
    assign y_hi_o = half_y[1];
    assign y_o    = route.top_sel ? half_y[1] : half_y[0];

    always_comb begin
        logic [2:0] k;
        k = {tbs_i, sel_a_i};
        if (mode == MC_MUX8) begin
            p_full_mux_path_r1: assert (y_o == (din_i[k] ^ cfg_inv_i[k]))
                else $error("p_full_mux_path_r1");
        end
        if (mode == MC_DUAL) begin
            p_dual_top_high_r3: assert (y_o == y_hi_o)
                else $error("p_dual_top_high_r3");
        end
        if (mode == MC_LUT_FULL && cfg_lut_size_i == 2'd3) begin
            p_table_entry_r4: assert (y_o == ~cfg_inv_i[lut_addr_i])
                else $error("p_table_entry_r4");
        end
        if (mode == MC_LUT_HALF) begin
            p_half_table_low_r6: assert (y_o == y_lo_o)
                else $error("p_half_table_low_r6");
        end
    end
endmodule

// File: tb/mcell_core_test.sv
`timescale 1ns/1ps
module mcell_core_test;
    logic clk = 0;
    logic rst = 1;
    always #2.5 clk = ~clk;

    logic [1:0] mode, size, sa, sb;
    logic [7:0] inv, din;
    logic       tbs;
    logic [2:0] addr;
    logic       y, ylo, yhi;

    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;

    mcell_core uut (
        .cfg_mode_i(mode), .cfg_inv_i(inv), .cfg_lut_size_i(size),
        .din_i(din), .sel_a_i(sa), .sel_b_i(sb), .tbs_i(tbs),
        .lut_addr_i(addr), .y_o(y), .y_lo_o(ylo), .y_hi_o(yhi)
    );

    // behavioural model: returns {y, hi, lo}
    function automatic logic [2:0] model();
        int lo, hi, t, a, lim;
        logic [7:0] src;
        src = (mode >= 2) ? 8'hFF : din;
        case (mode)
            2'd0: begin lo = sa; hi = sa; t = tbs; end
            2'd1: begin lo = sa; hi = sb; t = 1; end
            2'd2: begin lim = size; a = addr % (1 << lim);
                        lo = a % 4; hi = a % 4; t = a / 4; end
            default: begin lim = (size > 2) ? 2 : size; a = addr % (1 << lim);
                        lo = a; hi = a; t = 0; end
        endcase
        model[0] = src[lo] ^ inv[lo];
        model[1] = src[4+hi] ^ inv[4+hi];
        model[2] = t ? model[1] : model[0];
    endfunction

    task automatic apply_check(input string req);
        logic [2:0] exp;
        @(negedge clk);
        exp = model();
        checks++;
        if ({y, yhi, ylo} !== exp) begin
            errors++;
            $display("FAIL %s mode=%0d size=%0d actual=%b expected=%b",
                     req, mode, size, {y, yhi, ylo}, exp);
        end
        @(posedge clk);
        #0.5;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        mode = 0; size = 0; sa = 0; sb = 0; inv = 0; din = 0; tbs = 0; addr = 0;
        repeat (3) @(posedge clk);
        rst = 0;
        #0.5;
        // R1: all-zero configuration gives 0
        apply_check("R1 zero");

        // R1 R2: full mux, sel_b_i random (no effect)
        for (int n = 0; n < 6; n++) begin
            mode = 0; inv = $urandom; din = $urandom;
            for (int k = 0; k < 8; k++) begin
                tbs = k[2]; sa = k[1:0]; sb = $urandom;
                addr = $urandom; size = $urandom;
                apply_check("R1 R2 full mux");
            end
        end

        // R3: dual halves in the same cycle, tbs random
        for (int n = 0; n < 4; n++) begin
            mode = 1; inv = $urandom; din = $urandom;
            for (int p = 0; p < 16; p++) begin
                sa = p[1:0]; sb = p[3:2]; tbs = $urandom;
                apply_check("R3 dual");
            end
        end

        // R4 R5 R7: full table, every size, noisy mux inputs
        for (int s = 0; s < 4; s++) begin
            for (int n = 0; n < 3; n++) begin
                mode = 2; size = s[1:0]; inv = $urandom;
                for (int a = 0; a < 8; a++) begin
                    addr = a[2:0]; din = $urandom; sa = $urandom;
                    sb = $urandom; tbs = $urandom;
                    apply_check(s == 3 ? "R4 R7 table3" : "R5 R7 narrow table");
                end
            end
        end

        // R6 R7: half table, size 3 acts as 2
        for (int s = 0; s < 4; s++) begin
            for (int n = 0; n < 3; n++) begin
                mode = 3; size = s[1:0]; inv = $urandom;
                for (int a = 0; a < 8; a++) begin
                    addr = a[2:0]; din = $urandom; sa = $urandom;
                    sb = $urandom; tbs = $urandom;
                    apply_check("R6 R7 half table");
                end
            end
        end

        // R4: truth table T = 8'b1001_0110 (odd parity) loaded inverted
        mode = 2; size = 3; inv = ~8'b1001_0110;
        for (int a = 0; a < 8; a++) begin
            addr = a[2:0];
            apply_check("R4 parity");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule